// File: doc/BRIEF.md
# Serial Synthesizer Register Loader

This block programs the control registers of a frequency synthesizer over a three-wire serial link made of a serial clock, a data line and a latch enable. Six register words sit on a parallel input bus. A one-cycle start pulse begins a load. The block shifts every word out as a full 32-bit frame, most significant bit first. It commits each frame with its own latch-enable pulse. The words go out from the highest register slot down to slot 0.

The serial clock idles low. Data changes only while the clock is low, so the receiver can sample it on the rising edge. The length of each clock half-period is a parameter counted in system clocks. The register words must stay stable while `busy` is high. When the last latch pulse ends, the block gives a single-cycle `done` pulse and returns to idle.

Top module: `synthRegLoader`

## Requirements
- R1: After reset, `sClk`, `sLatch`, `sData`, `busy` and `done` are all low.
- R2: Between two latch pulses there are exactly WORD_W (32) rising edges of `sClk`, so every frame is a full word.
- R3: Bits leave most significant bit first. The bit presented at the first rising `sClk` edge of a frame is bit WORD_W-1 of the word.
- R4: `sData` only changes while `sClk` is low. It holds its value for the whole time `sClk` is high.
- R5: Frames are sent from slot NUM_REGS-1 down to slot 0. With the default of six slots, the order is 5, 4, 3, 2, 1, 0. Bits [2:0] of each word carry the slot number, and that field arrives in the same descending order.
- R6: `sLatch` is never high while `sClk` is high, and it stays low throughout the shifting of a frame.
- R7: Each latch pulse lasts at least 2*HALF_DIV system clocks, which is one full serial clock period. `sLatch` returns low at least HALF_DIV system clocks before the next frame's first rising `sClk` edge.
- R8: Every high phase of `sClk` lasts exactly HALF_DIV system clocks.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running load still delivers exactly NUM_REGS frames with unchanged contents.
- R10: `busy` rises the cycle after an accepted `start` and stays high until the last latch pulse ends. At that point `done` is high for exactly one cycle, `busy` is low, and `sClk`, `sLatch` and `sData` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to load all register words |
| regWords | input | NUM_REGS*WORD_W | Register words; slot k is `regWords[k]`, held stable while busy |
| sClk | output | 1 | Serial clock, idles low |
| sData | output | 1 | Serial data, MSB first, changes while `sClk` is low |
| sLatch | output | 1 | Latch enable; a high pulse commits the frame just shifted |
| busy | output | 1 | High while a load sequence is running |
| done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
The bound checker watches the link on every cycle. It checks that data stays stable while the clock is high and that clock and latch are never high together. It also checks the exact high-phase width, the minimum latch width, the count of 32 clock edges before each latch, and that `done` is a single-cycle pulse that coincides with an idle line. Only the bench scenarios can show that the assembled frames equal the input words in the descending slot order, MSB first. They also show that a mid-sequence start leaves the frame sequence untouched and that the latch gap comes before the next frame.

// File: rtl/synthLoaderPkg.sv
package synthLoaderPkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LATA  = 3'd3,
    ST_LATB  = 3'd4,
    ST_GAP   = 3'd5
  } loaderStateT;

  typedef struct packed {
    logic loadFirst;
    logic loadNext;
    logic shiftBit;
    logic clearAll;
  } dpStrobeT;

endpackage

// File: rtl/loaderHalfTick.sv
module loaderHalfTick #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic tick
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] divCnt;

  assign tick = run && (divCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!run || tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/loaderDatapath.sv
module loaderDatapath
  import synthLoaderPkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NUM_REGS = 6
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpStrobeT                           stb,
  input  logic [NUM_REGS-1:0][WORD_W-1:0]    regWords,
  output logic                               txBit,
  output logic                               lastBit,
  output logic                               lastWord
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_REGS - 1);
  localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [IDX_W-1:0]  wordIdx;
  logic [IDX_W-1:0]  nextIdx;

  assign nextIdx  = wordIdx - 1'b1;
  assign txBit    = shiftReg[WORD_W-1];
  assign lastBit  = (bitCnt == TOP_BIT);
  assign lastWord = (wordIdx == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      wordIdx  <= '0;
    end else if (stb.clearAll) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      wordIdx  <= '0;
    end else if (stb.loadFirst) begin
      shiftReg <= regWords[TOP_IDX];
      bitCnt   <= '0;
      wordIdx  <= TOP_IDX;
    end else if (stb.loadNext) begin
      shiftReg <= regWords[nextIdx];
      bitCnt   <= '0;
      wordIdx  <= nextIdx;
    end else if (stb.shiftBit) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
      bitCnt   <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/loaderControl.sv
module loaderControl
  import synthLoaderPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     tick,
  input  logic     lastBit,
  input  logic     lastWord,
  output dpStrobeT stb,
  output logic     sClk,
  output logic     sLatch,
  output logic     busy,
  output logic     done
);
  loaderStateT state, stateNxt;
  logic        doneNxt;

  always_comb begin
    stateNxt = state;
    stb      = '0;
    doneNxt  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stateNxt      = ST_LOW;
          stb.loadFirst = 1'b1;
        end
      end
      ST_LOW: begin
        if (tick) stateNxt = ST_HIGH;
      end
      ST_HIGH: begin
        if (tick) begin
          if (lastBit) begin
            stateNxt = ST_LATA;
          end else begin
            stateNxt     = ST_LOW;
            stb.shiftBit = 1'b1;
          end
        end
      end
      ST_LATA: begin
        if (tick) stateNxt = ST_LATB;
      end
      ST_LATB: begin
        if (tick) begin
          if (lastWord) begin
            stateNxt     = ST_IDLE;
            doneNxt      = 1'b1;
            stb.clearAll = 1'b1;
          end else begin
            stateNxt     = ST_GAP;
            stb.loadNext = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tick) stateNxt = ST_LOW;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      sClk   <= 1'b0;
      sLatch <= 1'b0;
      done   <= 1'b0;
    end else begin
      state  <= stateNxt;
      sClk   <= (stateNxt == ST_HIGH);
      sLatch <= (stateNxt == ST_LATA) || (stateNxt == ST_LATB);
      done   <= doneNxt;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/synthRegLoader.sv
module synthRegLoader
  import synthLoaderPkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NUM_REGS = 6,
  parameter int HALF_DIV = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            start,
  input  logic [NUM_REGS-1:0][WORD_W-1:0] regWords,
  output logic                            sClk,
  output logic                            sData,
  output logic                            sLatch,
  output logic                            busy,
  output logic                            done
);
  dpStrobeT stb;
  logic     tick;
  logic     lastBit;
  logic     lastWord;

  loaderHalfTick #(.HALF_DIV(HALF_DIV)) uTick (
    .clk  (clk),
    .rstN (rstN),
    .run  (busy),
    .tick (tick)
  );

  loaderControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .tick     (tick),
    .lastBit  (lastBit),
    .lastWord (lastWord),
    .stb      (stb),
    .sClk     (sClk),
    .sLatch   (sLatch),
    .busy     (busy),
    .done     (done)
  );

  loaderDatapath #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regWords (regWords),
    .txBit    (sData),
    .lastBit  (lastBit),
    .lastWord (lastWord)
  );
endmodule

// File: rtl/synthRegLoaderChk.sv
module synthRegLoaderChk #(
  parameter int WORD_W   = 32,
  parameter int HALF_DIV = 3
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic sClk,
  input logic sData,
  input logic sLatch,
  input logic busy,
  input logic done
);
  logic        clkPrev;
  logic [15:0] hiRun;
  logic [15:0] latRun;
  logic [15:0] edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      hiRun   <= '0;
      latRun  <= '0;
      edgeCnt <= '0;
    end else begin
      clkPrev <= sClk;
      hiRun   <= sClk ? hiRun + 1'b1 : '0;
      latRun  <= sLatch ? latRun + 1'b1 : '0;
      if (sLatch)               edgeCnt <= '0;
      else if (sClk && !clkPrev) edgeCnt <= edgeCnt + 1'b1;
    end
  end

  // R4: data held while clock high
  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (sClk && $past(sClk)) |-> $stable(sData));

  // R6: latch and clock never high together
  a_r6_latch_clk_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    sLatch |-> !sClk);

  // R8: exact high-phase width
  a_r8_high_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sClk) |-> (hiRun == 16'(HALF_DIV)));

  // R7: latch pulse lasts a full serial period
  a_r7_latch_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sLatch) |-> (latRun >= 16'(2 * HALF_DIV)));

  // R2: full word before every latch
  a_r2_full_word: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sLatch) |-> (edgeCnt == 16'(WORD_W)));

  // R10: done is one cycle, idle line
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !sClk && !sLatch && !sData));
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  // R9: start during a run does not end it
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !sLatch) |=> busy);
endmodule

bind synthRegLoader synthRegLoaderChk #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .sClk   (sClk),
  .sData  (sData),
  .sLatch (sLatch),
  .busy   (busy),
  .done   (done)
);

// File: tb/tb_synthRegLoader.sv
module tb_synthRegLoader;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 32;
  localparam int NUM_REGS   = 6;
  localparam int HALF_DIV   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NUM_REGS-1:0][WORD_W-1:0] regWords = '0;
  logic sClk, sData, sLatch, busy, done;

  int checks = 0;
  int failures = 0;
  logic [WORD_W-1:0] expQ[$];
  int latchesSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synthRegLoader #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .HALF_DIV(HALF_DIV)) dut (
    .clk(clk), .rstN(rstN), .start(start), .regWords(regWords),
    .sClk(sClk), .sData(sData), .sLatch(sLatch), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: sampled on the falling system clock edge
  logic clkQ = 1'b0, latQ = 1'b0, datQ = 1'b0;
  logic [WORD_W-1:0] rxWord = '0;
  int rxBits = 0, hiW = 0, latW = 0, gapW = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (sClk && !clkQ) begin
        check(!sLatch, "R6", "latch high at rising sClk", 32'(sLatch), 0);
        if (rxBits == 0)
          check(gapW >= HALF_DIV, "R7", "latch-to-clock gap", 32'(gapW), HALF_DIV);
        rxWord = {rxWord[WORD_W-2:0], sData};
        rxBits++;
      end
      if (sClk && clkQ)
        check(sData == datQ, "R4", "data moved while sClk high", 32'(sData), 32'(datQ));
      if (sClk) hiW++;
      if (!sClk && clkQ) begin
        check(hiW == HALF_DIV, "R8", "sClk high width", 32'(hiW), HALF_DIV);
        hiW = 0;
      end
      if (sLatch) begin
        latW++;
        check(busy, "R10", "busy low during latch", 32'(busy), 1);
      end
      if (sLatch && !latQ) begin
        check(rxBits == WORD_W, "R2", "bits per frame", 32'(rxBits), WORD_W);
        if (expQ.size() == 0) begin
          check(0, "R9", "unexpected extra frame", rxWord, 0);
        end else begin
          logic [WORD_W-1:0] e;
          e = expQ.pop_front();
          check(rxWord[2:0] == e[2:0], "R5", "slot field order", 32'(rxWord[2:0]), 32'(e[2:0]));
          check(rxWord == e, "R3", "frame value MSB first", rxWord, e);
        end
        latchesSeen++;
        rxBits = 0;
      end
      if (!sLatch && latQ) begin
        check(latW >= 2*HALF_DIV, "R7", "latch width", 32'(latW), 2*HALF_DIV);
        latW = 0;
        gapW = 0;
      end
      if (!sLatch && !sClk) gapW++;
      clkQ = sClk; latQ = sLatch; datQ = sData;
    end
  end

  task automatic runSeq(input logic [28:0] pat, input bit extraStart);
    for (int k = 0; k < NUM_REGS; k++)
      regWords[k] = {pat ^ 29'(k * 32'h0135_79BD), 3'(k)};
    for (int k = NUM_REGS-1; k >= 0; k--) expQ.push_back(regWords[k]);
    latchesSeen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy, "R10", "busy after start", 32'(busy), 1);
    if (extraStart) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(!busy && !sClk && !sLatch && !sData, "R10", "idle line at done",
          {28'd0, busy, sClk, sLatch, sData}, 0);
    @(negedge clk);
    check(!done, "R10", "done width", 32'(done), 0);
    check(expQ.size() == 0, "R9", "frames left unsent", 32'(expQ.size()), 0);
    check(latchesSeen == NUM_REGS, "R9", "frames per load", 32'(latchesSeen), NUM_REGS);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!sClk && !sLatch && !sData && !busy && !done, "R1", "reset outputs",
          {27'd0, sClk, sLatch, sData, busy, done}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!sClk && !sLatch && !busy && !done, "R1", "idle after reset",
          {28'd0, sClk, sLatch, busy, done}, 0);
    runSeq(29'h0A5A_5A5A, 1'b0);
    runSeq(29'h1FFF_FFFF, 1'b0);
    runSeq(29'h0000_0000, 1'b0);
    runSeq(29'h1234_5678, 1'b1);
    runSeq(29'h1555_5555, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule